// File: doc/BRIEF.md
# Shared Host Memory Request Front End

This block lets on-chip logic treat a region of host memory as if it were a local memory bank. User logic talks to three handshaked ports: one that writes an element, one that asks for an element to be read, and one that later collects the returned read data. Each accepted request is turned into a byte address and queued. A simple single-beat bus master then sends the queued requests to the host one at a time. Reads can be outstanding while new requests keep arriving, and read data comes back to the collecting port in the order the reads were asked for.

The region is sized in whole megabytes and holds 64-bit elements, whatever width the user data has. Indices at or past the end of the region never reach the bus and are reported on an error output. A link-enable input stands for whether the host side is ready. While it is low, requests pile up in the queue. When the queue is full, the user ports stop accepting new requests.

Top module: `hmem_front`

## Requirements
- R1: While `link_en` is low, `bus_req` stays low and accepted requests are held. Once REQ_DEPTH in-range requests are queued, `wr_ready` and `rq_ready` stay low until the queue drains after `link_en` rises.
- R2: Queued requests reach the bus in exactly the order they were accepted. None is dropped, reordered or merged, including across a low-to-high change of `link_en`.
- R3: Each element is one single-beat bus transaction at `bus_addr` = BASE_ADDR + index × 8. While `bus_req` waits for `bus_gnt` with the link enabled, the request does not change.
- R4: Write data is zero-extended from DATA_W to 64 bits on `bus_wdata`.
- R5: A read takes two steps: the request is accepted on the rq port, and the data is later taken on the rt port. `rt_data` carries bits [DATA_W-1:0] of the 64-bit bus word, in read-request order.
- R6: Up to REQ_DEPTH reads can be issued to the bus before any data returns or is retrieved. Returned and unretrieved reads together never exceed REQ_DEPTH, so further reads wait in the queue.
- R7: The region size is REGION_KB rounded up to whole megabytes, limited to 1 to 4 MB. It holds 131072 elements per megabyte.
- R8: A write to an index ≥ the element count is accepted, makes `wr_err` high for the one cycle after the handshake, and produces no bus transaction.
- R9: A read of an index ≥ the element count makes `rq_err` high for the one cycle after the handshake and produces no bus transaction. Its rt slot keeps its place in order, with `rt_err` = 1 and `rt_data` = 0.
- R10: When `wr_valid` and `rq_valid` are both high in one cycle, the write is taken and `rq_ready` is low.
- R11: After reset, `wr_ready` and `rq_ready` are high, and `rt_valid`, `bus_req`, `wr_err` and `rq_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_en | input | 1 | Host side ready; gates bus issue |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted |
| wr_idx | input | IDX_W | Element index of the write |
| wr_data | input | DATA_W | Write data |
| wr_err | output | 1 | Out-of-range write seen last cycle |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request accepted |
| rq_idx | input | IDX_W | Element index of the read |
| rq_err | output | 1 | Out-of-range read seen last cycle |
| rt_valid | output | 1 | Read data available |
| rt_ready | input | 1 | User takes read data |
| rt_data | output | DATA_W | Read data, truncated |
| rt_err | output | 1 | This read slot was out of range |
| bus_req | output | 1 | Bus transaction request |
| bus_gnt | input | 1 | Bus accepts the request this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 64 | Write word |
| bus_rvalid | input | 1 | Read word returned, in issue order |
| bus_rdata | input | 64 | Returned read word |

## Verification
The queue-and-issue path is driven four ways. Writes are sent while the link is held off, which separates holding from dropping or early issue. Reads are sent with responses frozen and retrieval blocked, which exposes the outstanding-read limit. Indices are placed exactly at and one past the region end, and out-of-range reads are mixed behind in-flight good reads, which shows whether bounds and error-slot ordering are right. A long seeded random run toggles the link, grant, response and retrieve timing, so any reordering, loss or wrong read-after-write value shows up against a bench model of memory.

// File: rtl/hmem_pkg.sv
// Shared constants, request/response records and the region sizing rule
// for the host memory request front end.
package hmem_pkg;

    localparam int unsigned BUS_AW       = 32;      // bus byte address width
    localparam int unsigned WORD_W       = 64;      // element stride in bits
    localparam int unsigned STRIDE_LG2   = 3;       // log2 of stride in bytes
    localparam int unsigned ELEMS_PER_MB = 131072;  // 64-bit elements per MB
    localparam int unsigned MAX_MB       = 4;

    // One queued bus transaction (address already resolved).
    typedef struct packed {
        logic              we;
        logic              bad;
        logic [BUS_AW-1:0] addr;
        logic [WORD_W-1:0] data;
    } req_t;

    // One entry waiting on the retrieve port.
    typedef struct packed {
        logic              err;
        logic [WORD_W-1:0] data;
    } rsp_t;

    // Requested kilobytes rounded up to whole megabytes, clamped to 1..MAX_MB.
    function automatic int unsigned region_mb(input int unsigned kb);
        int unsigned mb;
        mb = (kb + 1023) / 1024;
        if (mb < 1) mb = 1;
        if (mb > MAX_MB) mb = MAX_MB;
        return mb;
    endfunction

endpackage

// File: rtl/hmem_fifo.sv
// hmem_fifo: synchronous first-in first-out store with registered pointers.
// Assumes the owner never pushes when full nor pops when empty; output is the
// head entry, valid whenever empty is low. Depth need not be a power of two.
module hmem_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] fill;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

    // Pointer and fill-level update with wrap at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            fill <= fill + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Status and head output.
    always_comb begin
        full  = (fill == CNT_W'(DEPTH));
        empty = (fill == '0);
        dout  = store[rd_ptr];
    end

    // R1 / R6: owner must respect the full flag.
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R2: nothing is taken from an empty store.
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/hmem_locate.sv
// hmem_locate: turns an element index into a bus byte address and flags
// whether the index lies inside the region. Purely combinational; assumes the
// region end fits in the bus address space.
module hmem_locate
    import hmem_pkg::*;
#(
    parameter int unsigned       IDX_W     = 20,
    parameter int unsigned       ELEMS     = 131072,
    parameter logic [BUS_AW-1:0] BASE_ADDR = '0
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [BUS_AW-1:0] addr,
    output logic              in_range
);

    logic [BUS_AW-1:0] offset;

    // Scale the index by the fixed stride and compare against the element count.
    always_comb begin
        offset   = BUS_AW'(idx) << STRIDE_LG2;
        addr     = BASE_ADDR + offset;
        in_range = (32'(idx) < ELEMS);
    end

endmodule

// File: rtl/hmem_front.sv
// hmem_front: user-side write / read-request / read-retrieve front end for a
// host memory region of 64-bit elements. Accepted requests are resolved to byte
// addresses and queued; the queue head is sent as one single-beat transaction
// while link_en is high. Assumes the bus returns read data in issue order and
// asserts bus_rvalid only while a read is outstanding.
module hmem_front
    import hmem_pkg::*;
#(
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       IDX_W     = 20,
    parameter int unsigned       REQ_DEPTH = 4,
    parameter int unsigned       REGION_KB = 1500,
    parameter logic [BUS_AW-1:0] BASE_ADDR = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_en,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    input  logic              rq_valid,
    output logic              rq_ready,
    input  logic [IDX_W-1:0]  rq_idx,
    output logic              rq_err,
    output logic              rt_valid,
    input  logic              rt_ready,
    output logic [DATA_W-1:0] rt_data,
    output logic              rt_err,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_rvalid,
    input  logic [WORD_W-1:0] bus_rdata
);

    localparam int unsigned REGION_MB = region_mb(REGION_KB);
    localparam int unsigned ELEMS     = REGION_MB * ELEMS_PER_MB;
    localparam int unsigned CNT_W     = $clog2(REQ_DEPTH + 1);
    localparam logic [BUS_AW:0] LIMIT =
        (BUS_AW+1)'(BASE_ADDR) + ((BUS_AW+1)'(ELEMS) << STRIDE_LG2);

    // Index resolution for both request ports.
    logic [BUS_AW-1:0] wr_addr, rq_addr;
    logic              wr_inr, rq_inr;

    hmem_locate #(.IDX_W(IDX_W), .ELEMS(ELEMS), .BASE_ADDR(BASE_ADDR)) u_wr_loc (
        .idx(wr_idx), .addr(wr_addr), .in_range(wr_inr));

    hmem_locate #(.IDX_W(IDX_W), .ELEMS(ELEMS), .BASE_ADDR(BASE_ADDR)) u_rq_loc (
        .idx(rq_idx), .addr(rq_addr), .in_range(rq_inr));

    // Request queue.
    req_t req_din, req_head;
    logic req_push, req_pop, req_full, req_empty;

    hmem_fifo #(.WIDTH($bits(req_t)), .DEPTH(REQ_DEPTH)) u_req_q (
        .clk(clk), .rst_n(rst_n), .push(req_push), .din(req_din),
        .pop(req_pop), .dout(req_head), .full(req_full), .empty(req_empty));

    // Response queue.
    rsp_t rsp_din, rsp_head;
    logic rsp_push, rsp_pop, rsp_full, rsp_empty;

    hmem_fifo #(.WIDTH($bits(rsp_t)), .DEPTH(REQ_DEPTH)) u_rsp_q (
        .clk(clk), .rst_n(rst_n), .push(rsp_push), .din(rsp_din),
        .pop(rsp_pop), .dout(rsp_head), .full(rsp_full), .empty(rsp_empty));

    logic             wr_fire, rq_fire;
    logic             head_live, rd_room, bad_take, issue_go, rd_issue, rd_take;
    logic [CNT_W-1:0] in_flight;   // reads issued, data not yet returned
    logic [CNT_W-1:0] slots_used;  // reads taken from the queue, not yet retrieved

    // Enqueue side: write has priority; the record is resolved here.
    always_comb begin
        wr_ready = !req_full;
        rq_ready = !req_full && !wr_valid;
        wr_fire  = wr_valid && wr_ready;
        rq_fire  = rq_valid && rq_ready;
        req_push = (wr_fire && wr_inr) || rq_fire;
        if (wr_fire) begin
            req_din.we   = 1'b1;
            req_din.bad  = 1'b0;
            req_din.addr = wr_addr;
            req_din.data = WORD_W'(wr_data);
        end else begin
            req_din.we   = 1'b0;
            req_din.bad  = !rq_inr;
            req_din.addr = rq_addr;
            req_din.data = '0;
        end
    end

    // Issue side: one head entry per grant; bad reads wait for in-flight reads.
    always_comb begin
        head_live = !req_empty && link_en;
        rd_room   = (slots_used < CNT_W'(REQ_DEPTH));
        bus_req   = head_live && (req_head.we || (!req_head.bad && rd_room));
        bus_we    = req_head.we;
        bus_addr  = req_head.addr;
        bus_wdata = req_head.data;
        bad_take  = head_live && !req_head.we && req_head.bad && rd_room &&
                    (in_flight == '0);
        issue_go  = bus_req && bus_gnt;
        rd_issue  = issue_go && !req_head.we;
        rd_take   = rd_issue || bad_take;
        req_pop   = issue_go || bad_take;
    end

    // Response side: returned words or error slots, then the retrieve port.
    always_comb begin
        rsp_push     = bus_rvalid || bad_take;
        rsp_din.err  = bad_take;
        rsp_din.data = bad_take ? '0 : bus_rdata;
        rt_valid     = !rsp_empty;
        rsp_pop      = rt_valid && rt_ready;
        rt_data      = rsp_head.data[DATA_W-1:0];
        rt_err       = rsp_head.err;
    end

    if (DATA_W < WORD_W) begin : g_trunc
        logic unused_upper;
        assign unused_upper = ^rsp_head.data[WORD_W-1:DATA_W];
    end

    // Read bookkeeping counters for ordering and response-space reservation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flight  <= '0;
            slots_used <= '0;
        end else begin
            in_flight  <= in_flight + CNT_W'(rd_issue) - CNT_W'(bus_rvalid);
            slots_used <= slots_used + CNT_W'(rd_take) - CNT_W'(rsp_pop);
        end
    end

    // One-cycle error pulses for out-of-range handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
            rq_err <= 1'b0;
        end else begin
            wr_err <= wr_fire && !wr_inr;
            rq_err <= rq_fire && !rq_inr;
        end
    end

    // R1: no bus activity while the link is off.
    p_link_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> link_en);

    // R3 / R8: issued addresses lie in the region and on the 8-byte stride.
    p_addr_in_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr >= BASE_ADDR) && ({1'b0, bus_addr} < LIMIT) &&
                    (bus_addr[STRIDE_LG2-1:0] == '0));

    // R3: a waiting request holds still while the link stays on.
    p_hold_until_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && link_en) |=> !link_en ||
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R6: response space is never over-reserved; returns match issued reads.
    p_slot_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slots_used <= CNT_W'(REQ_DEPTH));
    p_return_matches_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (in_flight != '0));
    p_rsp_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_push |-> !rsp_full);

    // R8 / R9: error pulses only follow a handshake on their own port.
    p_wr_err_after_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_valid && wr_ready));
    p_rq_err_after_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rq_err |-> $past(rq_valid && rq_ready));

endmodule

// File: tb/hmem_front_bench.sv
// Bench for hmem_front: seeded random traffic plus directed corner cases,
// checked against a bench memory model and expected-order queues.
module hmem_front_bench;

    localparam int          DW   = 32;
    localparam int          IW   = 20;
    localparam int          DEP  = 4;
    localparam int          KB   = 1500;
    localparam logic [31:0] BASE = 32'h8000_0000;

    function automatic int exp_elems(input int kb);
        int mb;
        mb = (kb + 1023) / 1024;
        if (mb < 1) mb = 1;
        if (mb > 4) mb = 4;
        return mb * 131072;
    endfunction

    localparam int ELEMS     = exp_elems(KB);
    localparam int CAP_ELEMS = exp_elems(9000);

    typedef struct packed { logic we; logic [31:0] addr; logic [63:0] data; } bop_t;
    typedef struct packed { logic err; logic [DW-1:0] data; } rte_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          link_en;
    logic          wr_valid, wr_ready, wr_err;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data;
    logic          rq_valid, rq_ready, rq_err;
    logic [IW-1:0] rq_idx;
    logic          rt_valid, rt_ready, rt_err;
    logic [DW-1:0] rt_data;
    logic          bus_req, bus_gnt, bus_we, bus_rvalid;
    logic [31:0]   bus_addr;
    logic [63:0]   bus_wdata, bus_rdata;

    // second instance: region request above the 4 MB ceiling
    logic          c_wr_valid, c_wr_ready, c_wr_err, c_rq_ready, c_rq_err;
    logic [IW-1:0] c_wr_idx;
    logic          c_rt_valid, c_rt_err, c_bus_req, c_bus_we;
    logic [DW-1:0] c_rt_data;
    logic [31:0]   c_bus_addr;
    logic [63:0]   c_bus_wdata;

    always #5 clk = ~clk;

    hmem_front #(.DATA_W(DW), .IDX_W(IW), .REQ_DEPTH(DEP), .REGION_KB(KB),
                 .BASE_ADDR(BASE)) u_hmem_front (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_err(wr_err),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_idx(rq_idx), .rq_err(rq_err),
        .rt_valid(rt_valid), .rt_ready(rt_ready), .rt_data(rt_data), .rt_err(rt_err),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata));

    hmem_front #(.DATA_W(DW), .IDX_W(IW), .REQ_DEPTH(DEP), .REGION_KB(9000),
                 .BASE_ADDR(BASE)) u_hmem_front_cap (
        .clk(clk), .rst_n(rst_n), .link_en(1'b1),
        .wr_valid(c_wr_valid), .wr_ready(c_wr_ready), .wr_idx(c_wr_idx),
        .wr_data(32'h1), .wr_err(c_wr_err),
        .rq_valid(1'b0), .rq_ready(c_rq_ready), .rq_idx('0), .rq_err(c_rq_err),
        .rt_valid(c_rt_valid), .rt_ready(1'b1), .rt_data(c_rt_data), .rt_err(c_rt_err),
        .bus_req(c_bus_req), .bus_gnt(1'b1), .bus_we(c_bus_we), .bus_addr(c_bus_addr),
        .bus_wdata(c_bus_wdata), .bus_rvalid(1'b0), .bus_rdata(64'h0));

    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    bop_t        exp_bus[$];
    rte_t        exp_rt[$];
    logic [63:0] pend[$];
    logic [63:0] mem [logic [31:0]];
    logic [63:0] shadow [int];
    int          gnt_pct = 100;
    int          rsp_pct = 100;
    int          bus_ops = 0;
    int          rd_issues = 0;
    bit          last_wr_acc, last_rq_acc;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] eaddr(input int idx);
        return BASE + 32'(idx) * 32'd8;
    endfunction

    function automatic logic [DW-1:0] exp_read(input int idx);
        if (shadow.exists(idx)) return shadow[idx][DW-1:0];
        return '0;
    endfunction

    // One clock: inputs already set; evaluate handshakes, advance, check pulses.
    task automatic cycle();
        bit   do_rsp, wr_bad, rq_bad, nxt_wr_err, nxt_rq_err;
        bop_t b;
        rte_t r;
        bus_gnt    = (($urandom % 100) < gnt_pct);
        do_rsp     = (pend.size() > 0) && (($urandom % 100) < rsp_pct);
        bus_rvalid = do_rsp;
        bus_rdata  = do_rsp ? pend[0] : 64'hDEAD_BEEF_0BAD_F00D;
        #1;
        if (!link_en) check(!bus_req, "R1", "bus request while link off", 64'(bus_req), 0);
        if (bus_req && bus_gnt) begin
            bus_ops++;
            if (exp_bus.size() == 0) begin
                check(0, "R2", "unexpected bus transaction", 64'(bus_addr), 0);
            end else begin
                b = exp_bus.pop_front();
                check(bus_we === b.we && bus_addr === b.addr, "R3",
                      "bus kind and address", {31'b0, bus_we, bus_addr}, {31'b0, b.we, b.addr});
                if (b.we) begin
                    check(bus_wdata === b.data, "R4", "zero-extended write word", bus_wdata, b.data);
                    mem[bus_addr] = bus_wdata;
                end else begin
                    rd_issues++;
                    pend.push_back(mem.exists(bus_addr) ? mem[bus_addr] : 64'h0);
                end
            end
        end
        if (do_rsp) void'(pend.pop_front());
        if (rt_valid && rt_ready) begin
            if (exp_rt.size() == 0) begin
                check(0, "R5", "unexpected retrieve", 64'(rt_data), 0);
            end else begin
                r = exp_rt.pop_front();
                check(rt_err === r.err && rt_data === r.data, r.err ? "R9" : "R5",
                      "retrieve err and data", 64'({rt_err, rt_data}), 64'({r.err, r.data}));
            end
        end
        last_wr_acc = wr_valid && wr_ready;
        last_rq_acc = rq_valid && rq_ready;
        wr_bad = int'(wr_idx) >= ELEMS;
        rq_bad = int'(rq_idx) >= ELEMS;
        if (last_wr_acc && !wr_bad) begin
            exp_bus.push_back({1'b1, eaddr(int'(wr_idx)), 64'(wr_data)});
            shadow[int'(wr_idx)] = 64'(wr_data);
        end
        if (last_rq_acc) begin
            if (rq_bad) exp_rt.push_back({1'b1, {DW{1'b0}}});
            else begin
                exp_bus.push_back({1'b0, eaddr(int'(rq_idx)), 64'h0});
                exp_rt.push_back({1'b0, exp_read(int'(rq_idx))});
            end
        end
        nxt_wr_err = last_wr_acc && wr_bad;
        nxt_rq_err = last_rq_acc && rq_bad;
        @(posedge clk);
        @(negedge clk);
        if (nxt_wr_err || wr_err) check(wr_err === nxt_wr_err, "R8", "write error pulse", 64'(wr_err), 64'(nxt_wr_err));
        if (nxt_rq_err || rq_err) check(rq_err === nxt_rq_err, "R9", "read error pulse", 64'(rq_err), 64'(nxt_rq_err));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic do_write(input int idx, input logic [DW-1:0] d);
        wr_valid = 1'b1;
        wr_idx   = IW'(idx);
        wr_data  = d;
        for (int i = 0; i < 500; i++) begin
            cycle();
            if (last_wr_acc) break;
            if (i == 499) check(0, "R1", "write never accepted", 0, 1);
        end
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input int idx);
        rq_valid = 1'b1;
        rq_idx   = IW'(idx);
        for (int i = 0; i < 500; i++) begin
            cycle();
            if (last_rq_acc) break;
            if (i == 499) check(0, "R1", "read never accepted", 0, 1);
        end
        rq_valid = 1'b0;
    endtask

    task automatic drain();
        link_en = 1'b1; gnt_pct = 100; rsp_pct = 100; rt_ready = 1'b1;
        wr_valid = 1'b0; rq_valid = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            if (exp_bus.size() == 0 && exp_rt.size() == 0 && pend.size() == 0 && !rt_valid) break;
            cycle();
        end
        check(exp_bus.size() == 0 && exp_rt.size() == 0, "R2", "all requests completed",
              64'(exp_bus.size() + exp_rt.size()), 0);
    endtask

    function automatic int rand_idx();
        if (($urandom % 16) == 0) return ELEMS + int'($urandom % 4);
        return int'($urandom % 16);
    endfunction

    initial begin
        int base_ops, base_rd;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; link_en = 1'b0;
        wr_valid = 1'b0; wr_idx = '0; wr_data = '0;
        rq_valid = 1'b0; rq_idx = '0; rt_ready = 1'b0;
        bus_gnt = 1'b0; bus_rvalid = 1'b0; bus_rdata = '0;
        c_wr_valid = 1'b0; c_wr_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: reset state
        check(wr_ready && rq_ready, "R11", "readies after reset", 64'({wr_ready, rq_ready}), 64'h3);
        check(!rt_valid && !bus_req && !wr_err && !rq_err, "R11", "idle outputs after reset",
              64'({rt_valid, bus_req, wr_err, rq_err}), 0);

        // R1: link off, fill queue, readies fall, nothing issued
        base_ops = bus_ops;
        for (int i = 0; i < DEP; i++) do_write(i, DW'(32'h1111_1111 * (i + 1)));
        wr_valid = 1'b1; wr_idx = IW'(4); wr_data = 32'h5555_5555;
        #1;
        check(!wr_ready && !rq_ready, "R1", "readies low when queue full",
              64'({wr_ready, rq_ready}), 0);
        idle(3);
        check(!last_wr_acc && bus_ops == base_ops, "R1", "held with link off",
              64'(bus_ops - base_ops), 0);
        // R2: enable link, queued writes drain in order
        link_en = 1'b1;
        do_write(4, 32'h5555_5555);
        drain();
        check(bus_ops - base_ops == DEP + 1, "R2", "drained transaction count",
              64'(bus_ops - base_ops), 64'(DEP + 1));

        // R4: all-ones narrow write is zero-extended
        do_write(5, 32'hFFFF_FFFF);
        drain();

        // R5: two-step reads, truncation of a full 64-bit word
        mem[eaddr(100)] = 64'hA5A5_0000_1234_5678;
        shadow[100]     = 64'hA5A5_0000_1234_5678;
        rt_ready = 1'b0;
        do_read(100);
        do_read(5);
        do_read(2);
        idle(4);
        check(rt_valid, "R5", "data waits for retrieve", 64'(rt_valid), 1);
        drain();

        // R6: outstanding reads up to the depth, then stall
        rt_ready = 1'b0; rsp_pct = 0;
        base_rd = rd_issues;
        for (int i = 0; i < DEP; i++) do_read(i);
        idle(5);
        check(rd_issues - base_rd == DEP && pend.size() == DEP, "R6", "reads outstanding",
              64'(rd_issues - base_rd), 64'(DEP));
        do_read(1);
        idle(3);
        check(rd_issues - base_rd == DEP, "R6", "read held without slot",
              64'(rd_issues - base_rd), 64'(DEP));
        drain();

        // R7 / R8 / R9: region boundary on the default instance
        do_write(ELEMS - 1, 32'hCAFE_0001);
        do_write(ELEMS, 32'hBAD0_0001);
        drain();
        rsp_pct = 0; rt_ready = 1'b0;
        do_read(3);
        do_read(ELEMS + 5);
        do_read(ELEMS - 1);
        idle(4);
        drain();

        // R10: simultaneous write and read, write first, read sees new value
        wr_valid = 1'b1; wr_idx = IW'(7); wr_data = 32'h7777_0007;
        rq_valid = 1'b1; rq_idx = IW'(7);
        #1;
        check(wr_ready && !rq_ready, "R10", "write wins arbitration",
              64'({wr_ready, rq_ready}), 64'h2);
        cycle();
        wr_valid = 1'b0;
        do_read(7);
        drain();

        // Random mixed traffic with link, grant, response and retrieve jitter
        gnt_pct = 60; rsp_pct = 50;
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 20) == 0) link_en = ~link_en;
            wr_valid = (($urandom % 3) == 0);
            wr_idx   = IW'(rand_idx());
            wr_data  = DW'($urandom);
            rq_valid = (($urandom % 3) == 0);
            rq_idx   = IW'(rand_idx());
            rt_ready = $urandom % 2;
            cycle();
        end
        drain();

        // R7: region request above the ceiling is clamped to 4 MB
        c_wr_valid = 1'b1; c_wr_idx = IW'(CAP_ELEMS - 1);
        @(posedge clk); @(negedge clk);
        check(c_wr_err === 1'b0, "R7", "last element of clamped region", 64'(c_wr_err), 0);
        c_wr_idx = IW'(CAP_ELEMS);
        @(posedge clk); @(negedge clk);
        check(c_wr_err === 1'b1, "R7", "first element past clamped region", 64'(c_wr_err), 1);
        c_wr_valid = 1'b0;
        @(posedge clk); @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule